// File: doc/BRIEF.md
# Descriptor-Walking Bus-Master DMA Engine

This block moves one device transfer of known length between a 16-bit device data stream and a simple memory port. Before each transfer the host loads the address of a table of 8-byte descriptors. Each descriptor names a memory buffer and its byte length, and one of them carries an end-of-table flag. The engine reads the descriptors from memory one after another. It fills the buffers from the device, or drains the buffers to the device, and stops when the transfer is complete or the table is used up, whichever comes first.

When the engine stops, the status bits tell the host how the descriptor space compared with the device transfer. Equal space raises the interrupt bit and drops the active bit. Larger space raises the interrupt bit and keeps the active bit set until the host clears the start bit. Smaller space leaves both bits clear, which the host treats as an error. If the host clears the start bit before the transfer ends, no more data moves. The engine still walks the rest of the table without moving data, so that the interrupt bit reports whether the space would have covered the transfer.

Top module: `prd_dma_engine`

## Requirements
- R1: After reset, cmd_start, cmd_to_mem, stat_active, stat_irq, table_ptr and mem_req are all zero.
- R2: A write to the table register (reg_sel 2) stores reg_wdata with bits 1:0 forced to zero, and table_ptr never shows a nonzero value in bits 1:0.
- R3: A command write (reg_sel 0) with bit 0 set, while the engine is idle and cmd_start is clear, sets stat_active and starts the table walk at table_ptr. Bit 3 set selects device-to-memory, and bit 3 clear selects memory-to-device. A command write with bit 0 clear clears stat_active. stat_active only rises after a start write.
- R4: A descriptor is read as four halfwords at offsets 0, 2, 4 and 6 from its table address. Halfwords 0 and 1 hold the low and high halves of the buffer address. Halfword 2 is the byte count, where bit 0 is ignored and a value of zero (after bit 0 is dropped) means 65536 bytes. Bit 15 of halfword 3 is the end-of-table flag, and the other bits of halfword 3 are ignored. Every memory access uses an even address.
- R5: In device-to-memory mode, each accepted dev_in beat is written to consecutive halfwords, filling the buffers in table order. No memory write occurs without an accepted device beat.
- R6: In memory-to-device mode, dev_out_data carries the buffer halfwords in table order, and the engine reads memory in every cycle in which dev_out_valid is high.
- R7: When the descriptor space equals the transfer length, the engine ends with stat_irq = 1 and stat_active = 0.
- R8: When the descriptor space exceeds the transfer length, including a transfer that ends exactly at the end of a descriptor without the end flag, the engine ends with stat_irq = 1 and stat_active = 1. It moves exactly the transfer length and touches no further buffer halfword.
- R9: When the descriptor space is smaller than the transfer length, the engine moves all of the space and then ends with stat_irq = 0 and stat_active = 0.
- R10: A stop write issued during a transfer clears stat_active at once, and no data beat is offered afterwards. Once the table walk ends, stat_irq is 1 if the total descriptor space is at least the transfer length, and 0 otherwise.
- R11: A status write (reg_sel 1) with bit 2 set clears stat_irq. All other status bits and writes have no effect, and stat_irq is otherwise sticky.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 command, 1 status, 2 table pointer |
| reg_wdata | input | 32 | Register write data |
| xfer_bytes | input | XLEN_W | Device transfer length in bytes (even, nonzero), sampled at start |
| cmd_start | output | 1 | Command start bit |
| cmd_to_mem | output | 1 | Command direction bit (1 = device to memory) |
| stat_active | output | 1 | Status active bit |
| stat_irq | output | 1 | Status interrupt bit |
| table_ptr | output | 32 | Descriptor table pointer |
| mem_req | output | 1 | Memory access request (always accepted) |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 32 | Memory byte address (even) |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid in the request cycle |
| dev_in_valid | input | 1 | Device has a halfword for memory |
| dev_in_data | input | 16 | Device halfword for memory |
| dev_in_ready | output | 1 | Engine accepts a device halfword |
| dev_out_valid | output | 1 | Engine offers a halfword to the device |
| dev_out_data | output | 16 | Halfword for the device |
| dev_out_ready | input | 1 | Device accepts the offered halfword |

## Verification
The assertions check on every cycle the rules that hold for any descriptor table. The pointer is aligned and every access is at an even address. A memory write happens only with an accepted device beat, and a device read is always backed by a memory read. Data is offered only in the direction selected and only while active. The active bit rises only after a start write, and the interrupt bit stays set until a clear write. The three-way outcome cannot be seen from a single cycle: equal, larger or smaller space, and the interrupt result after an abort. Neither can the halfword order across descriptors, the 64 KiB meaning of a zero count, or the halfword just past the last one moved staying untouched. Only the bench's scenarios, which compare whole transfers against the built table, show these.

// File: rtl/prd_dma_pkg.sv
package prd_dma_pkg;

    // Fixed by the descriptor format
    localparam int ADDR_W   = 32;
    localparam int BEAT_W   = 16;
    localparam int CNT_W    = 16;
    localparam int DESC_HW  = 4;   // halfwords per descriptor
    localparam int EOT_BIT  = 15;  // in the last halfword
    localparam int BEAT_BYTES = BEAT_W / 8;

    // Register selects and bit positions
    localparam logic [1:0] SEL_CMD   = 2'd0;
    localparam logic [1:0] SEL_STAT  = 2'd1;
    localparam logic [1:0] SEL_TABLE = 2'd2;
    localparam int CMD_GO_BIT    = 0;
    localparam int CMD_TOMEM_BIT = 3;
    localparam int STAT_IRQ_BIT  = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_MOVE  = 2'd2,
        ST_EVAL  = 2'd3
    } dma_state_e;

endpackage

// File: rtl/prd_dma_seglen.sv
module prd_dma_seglen #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] cnt_raw,
    output logic [CNT_W:0]   seg_bytes
);
    logic [CNT_W-1:0] even_cnt;

    always_comb begin
        even_cnt = {cnt_raw[CNT_W-1:1], 1'b0};
        if (even_cnt == '0) begin
            seg_bytes = {1'b1, {CNT_W{1'b0}}};
        end else begin
            seg_bytes = {1'b0, even_cnt};
        end
    end
endmodule

// File: rtl/prd_dma_stream.sv
module prd_dma_stream #(
    parameter int BEAT_W = 16
) (
    input  logic              moving,
    input  logic              to_mem,
    input  logic              dev_in_valid,
    input  logic [BEAT_W-1:0] dev_in_data,
    input  logic              dev_out_ready,
    input  logic [BEAT_W-1:0] mem_rdata,
    output logic              dev_in_ready,
    output logic              dev_out_valid,
    output logic [BEAT_W-1:0] dev_out_data,
    output logic              beat,
    output logic              data_req,
    output logic              data_we,
    output logic [BEAT_W-1:0] data_wdata
);
    always_comb begin
        dev_in_ready  = moving && to_mem;
        dev_out_valid = moving && !to_mem;
        dev_out_data  = mem_rdata;
        beat          = moving && (to_mem ? dev_in_valid : dev_out_ready);
        data_req      = moving && (to_mem ? dev_in_valid : 1'b1);
        data_we       = moving && to_mem && dev_in_valid;
        data_wdata    = dev_in_data;
    end
endmodule

// File: rtl/prd_dma_engine.sv
module prd_dma_engine
    import prd_dma_pkg::*;
#(
    parameter int XLEN_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [1:0]        reg_sel,
    input  logic [31:0]       reg_wdata,
    input  logic [XLEN_W-1:0] xfer_bytes,
    output logic              cmd_start,
    output logic              cmd_to_mem,
    output logic              stat_active,
    output logic              stat_irq,
    output logic [31:0]       table_ptr,
    output logic              mem_req,
    output logic              mem_we,
    output logic [31:0]       mem_addr,
    output logic [15:0]       mem_wdata,
    input  logic [15:0]       mem_rdata,
    input  logic              dev_in_valid,
    input  logic [15:0]       dev_in_data,
    output logic              dev_in_ready,
    output logic              dev_out_valid,
    output logic [15:0]       dev_out_data,
    input  logic              dev_out_ready
);
    localparam int SEG_W  = CNT_W + 1;
    localparam int FIDX_W = $clog2(DESC_HW);
    localparam int CMP_W  = (XLEN_W > SEG_W) ? XLEN_W : SEG_W;
    localparam logic [ADDR_W-1:0] DESC_STRIDE = ADDR_W'(DESC_HW * BEAT_BYTES);
    localparam logic [ADDR_W-1:0] BEAT_STEP   = ADDR_W'(BEAT_BYTES);
    localparam logic [FIDX_W-1:0] FIDX_LAST   = FIDX_W'(DESC_HW - 1);

    typedef struct packed {
        dma_state_e          st;
        logic                start;
        logic                to_mem;
        logic                active;
        logic                irq;
        logic                drain;
        logic                eot;
        logic [FIDX_W-1:0]   fidx;
        logic [ADDR_W-1:0]   tbl;
        logic [ADDR_W-1:0]   desc_ptr;
        logic [ADDR_W-1:0]   buf_addr;
        logic [CNT_W-1:0]    cnt_raw;
        logic [SEG_W-1:0]    seg_left;
        logic [XLEN_W-1:0]   rem;
    } eng_t;

    eng_t q, d;

    logic [SEG_W-1:0]  seg_dec;
    logic              beat, data_req, data_we, fetch_rd;
    logic [BEAT_W-1:0] data_wdata;
    logic              go_wr, halt_wr, seg_end, xfer_end;
    logic [CMP_W-1:0]  seg_ext, rem_ext;
    logic              unused_wbit;

    assign unused_wbit = reg_wdata[1];

    prd_dma_seglen #(.CNT_W(CNT_W)) seglen_i (
        .cnt_raw   (q.cnt_raw),
        .seg_bytes (seg_dec)
    );

    prd_dma_stream #(.BEAT_W(BEAT_W)) stream_i (
        .moving        (q.st == ST_MOVE),
        .to_mem        (q.to_mem),
        .dev_in_valid  (dev_in_valid),
        .dev_in_data   (dev_in_data),
        .dev_out_ready (dev_out_ready),
        .mem_rdata     (mem_rdata),
        .dev_in_ready  (dev_in_ready),
        .dev_out_valid (dev_out_valid),
        .dev_out_data  (dev_out_data),
        .beat          (beat),
        .data_req      (data_req),
        .data_we       (data_we),
        .data_wdata    (data_wdata)
    );

    always_comb begin
        d        = q;
        fetch_rd = (q.st == ST_FETCH);
        go_wr    = reg_wr_en && (reg_sel == SEL_CMD) && reg_wdata[CMD_GO_BIT];
        halt_wr  = reg_wr_en && (reg_sel == SEL_CMD) && !reg_wdata[CMD_GO_BIT];
        seg_end  = (q.seg_left == SEG_W'(BEAT_BYTES));
        xfer_end = (q.rem == XLEN_W'(BEAT_BYTES));
        seg_ext  = CMP_W'(q.seg_left);
        rem_ext  = CMP_W'(q.rem);

        // Host register writes (interrupt clear first so a set wins)
        if (reg_wr_en && (reg_sel == SEL_STAT) && reg_wdata[STAT_IRQ_BIT]) begin
            d.irq = 1'b0;
        end
        if (reg_wr_en && (reg_sel == SEL_TABLE)) begin
            d.tbl = {reg_wdata[31:2], 2'b00};
        end
        if (reg_wr_en && (reg_sel == SEL_CMD)) begin
            d.start = reg_wdata[CMD_GO_BIT];
            if (q.st == ST_IDLE) begin
                d.to_mem = reg_wdata[CMD_TOMEM_BIT];
            end
        end

        case (q.st)
            ST_IDLE: begin
                if (go_wr && !q.start) begin
                    d.st       = ST_FETCH;
                    d.active   = 1'b1;
                    d.drain    = 1'b0;
                    d.fidx     = '0;
                    d.desc_ptr = q.tbl;
                    d.rem      = xfer_bytes;
                end
            end
            ST_FETCH: begin
                case (q.fidx)
                    2'd0: d.buf_addr[15:0]  = mem_rdata;
                    2'd1: d.buf_addr[31:16] = mem_rdata;
                    2'd2: d.cnt_raw         = mem_rdata;
                    default: d.eot          = mem_rdata[EOT_BIT];
                endcase
                d.fidx = q.fidx + 1'b1;
                if (q.fidx == FIDX_LAST) begin
                    d.seg_left = seg_dec;
                    d.desc_ptr = q.desc_ptr + DESC_STRIDE;
                    d.st       = q.drain ? ST_EVAL : ST_MOVE;
                end
            end
            ST_MOVE: begin
                if (beat) begin
                    d.buf_addr = q.buf_addr + BEAT_STEP;
                    d.seg_left = q.seg_left - SEG_W'(BEAT_BYTES);
                    d.rem      = q.rem - XLEN_W'(BEAT_BYTES);
                    if (xfer_end) begin
                        d.irq = 1'b1;
                        d.st  = ST_IDLE;
                        if (seg_end && q.eot) begin
                            d.active = 1'b0;
                        end
                    end else if (seg_end) begin
                        if (q.eot) begin
                            d.active = 1'b0;
                            d.st     = ST_IDLE;
                        end else begin
                            d.fidx = '0;
                            d.st   = ST_FETCH;
                        end
                    end
                end
            end
            default: begin  // ST_EVAL: space check without data movement
                if (seg_ext >= rem_ext) begin
                    d.irq = 1'b1;
                    d.st  = ST_IDLE;
                end else begin
                    d.rem = q.rem - XLEN_W'(q.seg_left);
                    if (q.eot) begin
                        d.st = ST_IDLE;
                    end else begin
                        d.fidx = '0;
                        d.st   = ST_FETCH;
                    end
                end
            end
        endcase

        // Host stop overrides the data path
        if (halt_wr && q.start) begin
            d.active = 1'b0;
            d.drain  = 1'b1;
            if (d.st == ST_MOVE) begin
                d.st = ST_EVAL;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign cmd_start   = q.start;
    assign cmd_to_mem  = q.to_mem;
    assign stat_active = q.active;
    assign stat_irq    = q.irq;
    assign table_ptr   = q.tbl;
    assign mem_req     = fetch_rd || data_req;
    assign mem_we      = data_we;
    assign mem_wdata   = data_wdata;
    assign mem_addr    = fetch_rd ? (q.desc_ptr + ADDR_W'({q.fidx, 1'b0}))
                                  : {q.buf_addr[ADDR_W-1:1], 1'b0};
endmodule

// File: rtl/prd_dma_checker.sv
module prd_dma_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr_en,
    input logic [1:0]  reg_sel,
    input logic [31:0] reg_wdata,
    input logic        cmd_to_mem,
    input logic        stat_active,
    input logic        stat_irq,
    input logic [31:0] table_ptr,
    input logic        mem_req,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic        dev_in_valid,
    input logic        dev_in_ready,
    input logic        dev_out_valid
);
    // R2
    table_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        table_ptr[1:0] == 2'b00);

    // R4
    even_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[0] == 1'b0));

    // R5
    write_needs_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (dev_in_valid && dev_in_ready));

    // R6
    out_backed_by_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dev_out_valid |-> (mem_req && !mem_we));

    // R3
    in_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dev_in_ready |-> cmd_to_mem);

    // R3
    out_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dev_out_valid |-> !cmd_to_mem);

    // R10
    move_only_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_in_ready || dev_out_valid) |-> stat_active);

    // R3
    active_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_active) |-> $past(reg_wr_en && reg_sel == 2'd0 && reg_wdata[0]));

    // R11
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_irq && !(reg_wr_en && reg_sel == 2'd1 && reg_wdata[2])) |=> stat_irq);
endmodule

bind prd_dma_engine prd_dma_checker chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_wr_en     (reg_wr_en),
    .reg_sel       (reg_sel),
    .reg_wdata     (reg_wdata),
    .cmd_to_mem    (cmd_to_mem),
    .stat_active   (stat_active),
    .stat_irq      (stat_irq),
    .table_ptr     (table_ptr),
    .mem_req       (mem_req),
    .mem_we        (mem_we),
    .mem_addr      (mem_addr),
    .dev_in_valid  (dev_in_valid),
    .dev_in_ready  (dev_in_ready),
    .dev_out_valid (dev_out_valid)
);

// File: tb/prd_dma_engine_tb_top.sv
`timescale 1ns/1ps
module prd_dma_engine_tb_top;
    localparam int XLEN_W = 18;
    localparam int MEM_HW = 4096;
    localparam int BUF_HW0 = 128;   // halfword index of byte 0x100

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic              reg_wr_en = 1'b0;
    logic [1:0]        reg_sel = '0;
    logic [31:0]       reg_wdata = '0;
    logic [XLEN_W-1:0] xfer_bytes = '0;
    logic cmd_start, cmd_to_mem, stat_active, stat_irq;
    logic [31:0] table_ptr, mem_addr;
    logic mem_req, mem_we;
    logic [15:0] mem_wdata, mem_rdata;
    logic dev_in_valid = 1'b0;
    logic [15:0] dev_in_data = '0;
    logic dev_in_ready, dev_out_valid;
    logic [15:0] dev_out_data;
    logic dev_out_ready = 1'b0;

    prd_dma_engine #(.XLEN_W(XLEN_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .xfer_bytes(xfer_bytes), .cmd_start(cmd_start),
        .cmd_to_mem(cmd_to_mem), .stat_active(stat_active), .stat_irq(stat_irq),
        .table_ptr(table_ptr), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .dev_in_valid(dev_in_valid), .dev_in_data(dev_in_data),
        .dev_in_ready(dev_in_ready), .dev_out_valid(dev_out_valid),
        .dev_out_data(dev_out_data), .dev_out_ready(dev_out_ready)
    );

    logic [15:0] mem [0:MEM_HW-1];
    assign mem_rdata = mem[mem_addr[12:1]];
    always @(posedge clk) begin
        if (mem_req && mem_we) mem[mem_addr[12:1]] <= mem_wdata;
    end

    int n_vec = 0;
    int n_bad = 0;

    int unsigned d_raw [4];
    int unsigned d_base[4];
    int unsigned d_len [4];
    logic [15:0] exp_w [2048];
    logic [15:0] got_w [2048];
    int          n_got;
    bit          run_done;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] sel, input logic [31:0] val);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_sel = sel; reg_wdata = val;
        @(negedge clk);
        reg_wr_en = 1'b0; reg_wdata = '0;
    endtask

    // R4: count bit 0 ignored, zero means 65536
    function automatic int unsigned seg_bytes(input int unsigned raw);
        int unsigned v;
        v = raw & 32'hFFFE;
        return (v == 0) ? 32'd65536 : v;
    endfunction

    function automatic int unsigned word_addr(input int nd, input int unsigned w);
        int unsigned off;
        off = 2 * w;
        for (int k = 0; k < nd; k++) begin
            if (off < d_len[k]) return d_base[k] + off;
            off -= d_len[k];
        end
        return 0;
    endfunction

    task automatic feed_in(input int nw);
        int idx = 0;
        while (!run_done) begin
            @(negedge clk);
            dev_in_valid = (idx < nw) && ($urandom % 4 != 0);
            dev_in_data  = exp_w[idx % 2048];
            #0.5;
            if (dev_in_valid && dev_in_ready) idx++;
        end
        dev_in_valid = 1'b0;
    endtask

    task automatic feed_out();
        n_got = 0;
        while (!run_done) begin
            @(negedge clk);
            dev_out_ready = ($urandom % 4 != 0);
            #0.5;
            if (dev_out_valid && dev_out_ready) begin
                if (n_got < 2048) got_w[n_got] = dev_out_data;
                n_got++;
            end
        end
        dev_out_ready = 1'b0;
    endtask

    task automatic run_case(input string tag, input int nd, input int unsigned xfer,
                            input bit to_mem, input bit abort, input bit keep);
        int unsigned tptr, addr, space, moved, bad, wa;
        int cyc;
        tptr = 8 * ($urandom % 16);
        for (int i = BUF_HW0; i < MEM_HW; i++) mem[i] = to_mem ? 16'hDEAD : 16'($urandom);
        addr = 32'h100;
        space = 0;
        for (int k = 0; k < nd; k++) begin
            d_base[k] = addr;
            d_len[k]  = seg_bytes(d_raw[k]);
            addr += d_len[k] + 2;
            space += d_len[k];
            mem[tptr/2 + 4*k]     = d_base[k][15:0];
            mem[tptr/2 + 4*k + 1] = d_base[k][31:16];
            mem[tptr/2 + 4*k + 2] = d_raw[k][15:0];
            mem[tptr/2 + 4*k + 3] = ((k == nd-1) ? 16'h8000 : 16'h0000) | 16'($urandom & 32'h7FFF);
        end
        moved = (xfer < space) ? xfer : space;
        for (int i = 0; i < 2048; i++) exp_w[i] = 16'($urandom);
        if (!to_mem) begin
            for (int w = 0; w < int'(moved/2); w++) exp_w[w] = mem[word_addr(nd, w) / 2 % MEM_HW];
        end
        xfer_bytes = XLEN_W'(xfer);
        run_done = 1'b0;
        reg_write(2'd2, tptr | ($urandom & 3));
        reg_write(2'd0, 32'h1 | (32'(to_mem) << 3));
        check({tag, " R3 start bit"}, cmd_start, 1);
        check({tag, " R3 direction bit"}, cmd_to_mem, to_mem);
        fork
            begin
                if (to_mem) feed_in(int'(xfer/2)); else feed_out();
            end
            begin
                if (abort) begin
                    reg_write(2'd0, 32'h0);
                    repeat (400) @(negedge clk);
                end else begin
                    cyc = 0;
                    while ((stat_active && !stat_irq) && cyc < 30000) begin
                        @(negedge clk); cyc++;
                    end
                    repeat (20) @(negedge clk);
                end
                run_done = 1'b1;
            end
        join
        if (abort) begin
            check({tag, " R10 active after stop"}, stat_active, 0);
            check({tag, " R10 irq after stop"}, stat_irq, (space >= xfer));
        end else begin
            check({tag, " irq outcome"}, stat_irq, (space >= xfer));
            check({tag, " active outcome"}, stat_active, (space > xfer));
            bad = 0;
            if (to_mem) begin
                for (int w = 0; w < int'(moved/2); w++) begin
                    wa = word_addr(nd, w);
                    if (mem[wa/2 % MEM_HW] !== exp_w[w]) bad++;
                end
                check({tag, " R5 buffer contents mismatches"}, bad, 0);
                if (space > xfer) begin
                    wa = word_addr(nd, moved/2);
                    check({tag, " R8 halfword past transfer untouched"}, mem[wa/2 % MEM_HW], 16'hDEAD);
                end
            end else begin
                check({tag, " R6 halfwords delivered"}, n_got, moved/2);
                for (int w = 0; w < int'(moved/2) && w < n_got; w++)
                    if (got_w[w] !== exp_w[w]) bad++;
                check({tag, " R6 stream mismatches"}, bad, 0);
            end
        end
        if (!keep) begin
            reg_write(2'd1, 32'h4);
            reg_write(2'd0, 32'h0);
            check({tag, " R11 irq cleared"}, stat_irq, 0);
            check({tag, " R3 idle after stop"}, stat_active, 0);
        end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int unsigned space, xfer;
        int nd;
        bit tm, ab;
        void'($urandom(32'd20240611));
        for (int i = 0; i < MEM_HW; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 start", cmd_start, 0);
        check("R1 dir", cmd_to_mem, 0);
        check("R1 active", stat_active, 0);
        check("R1 irq", stat_irq, 0);
        check("R1 table", table_ptr, 0);
        check("R1 mem_req", mem_req, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 pointer alignment
        reg_write(2'd2, 32'hFFFF_FFFF);
        check("R2 table low bits", table_ptr, 32'hFFFF_FFFC);

        d_raw[0] = 512;                      run_case("R7 exact", 1, 512, 1, 0, 0);
        d_raw[0] = 256;                      run_case("R8 larger", 1, 128, 0, 0, 0);
        d_raw[0] = 64; d_raw[1] = 64;        run_case("R9 smaller", 2, 256, 1, 0, 0);
        d_raw[0] = 64; d_raw[1] = 64;        run_case("R9 smaller out", 2, 256, 0, 0, 0);
        d_raw[0] = 513;                      run_case("R4 odd count", 1, 512, 1, 0, 0);
        d_raw[0] = 0;                        run_case("R4 zero count", 1, 64, 0, 0, 0);
        d_raw[0] = 1;                        run_case("R4 one count", 1, 64, 1, 0, 0);
        d_raw[0] = 64; d_raw[1] = 64; d_raw[2] = 64;
                                             run_case("R8 non-end boundary", 3, 128, 1, 0, 0);
        d_raw[0] = 128; d_raw[1] = 96;       run_case("R10 abort equal", 2, 224, 1, 1, 0);
        d_raw[0] = 128; d_raw[1] = 96;       run_case("R10 abort larger", 2, 100, 0, 1, 0);
        d_raw[0] = 128; d_raw[1] = 96;       run_case("R10 abort smaller", 2, 400, 1, 1, 0);

        // R11 write-one-to-clear, other bits ignored
        d_raw[0] = 256;
        run_case("R11 setup", 1, 64, 1, 0, 1);
        reg_write(2'd1, 32'h0000_00FB);
        check("R11 irq kept", stat_irq, 1);
        check("R11 active kept", stat_active, 1);
        reg_write(2'd1, 32'h4);
        check("R11 irq cleared", stat_irq, 0);
        check("R11 active unaffected", stat_active, 1);
        reg_write(2'd0, 32'h0);
        check("R3 stop clears active", stat_active, 0);

        // Random scenarios
        for (int t = 0; t < 24; t++) begin
            nd = 1 + int'($urandom % 4);
            space = 0;
            for (int k = 0; k < nd; k++) begin
                d_raw[k] = 4 + ($urandom % 765);
                space += seg_bytes(d_raw[k]);
            end
            case ($urandom % 3)
                0: xfer = space;
                1: xfer = 2 * (1 + ($urandom % (space/2 - 1)));
                default: xfer = space + 2 * (1 + ($urandom % 256));
            endcase
            tm = 1'($urandom);
            ab = ($urandom % 5 == 0);
            run_case(ab ? "R10 random" : (xfer == space ? "R7 random" :
                     (xfer < space ? "R8 random" : "R9 random")), nd, xfer, tm, ab, 0);
        end

        summary();
        $finish;
    end
endmodule